// File: doc/BRIEF.md
# Dual RC Servo Pulse Generator

This block drives two hobby-servo inputs on a model car: one steering servo and one drive speed controller. Each channel has a command code. A turn position goes to steering and a signed speed step goes to drive. Each channel emits one positive pulse per frame, and the pulse width carries the command. A clock divider makes a microsecond tick, and all frame and width counting runs on that tick.

Both channels share one frame counter, so their pulses always start together. Commands are captured only at the frame boundary. The width a servo sees is therefore always a whole width for one command, never a mix of two. After reset, the first frame is always the neutral or straight width, whatever the command inputs hold.

Top module: `servo_pulse_pair`

## Requirements
- R1: Both outputs rise on the same clock edge, once every FRAME_US ticks, which is FRAME_US*CLKS_PER_US clock cycles.
- R2: One tick lasts CLKS_PER_US clock cycles, so a width of W microseconds holds the output high for exactly W*CLKS_PER_US cycles.
- R3: Steering code (3 bits) to width: 0 gives 1500 µs (straight), 1 gives 1400 µs (slight left), 2 gives 1000 µs (full left), 3 gives 1600 µs (slight right), 4 gives 2000 µs (full right).
- R4: Drive code is a signed 4-bit two's complement value. Its width is 1500 µs minus round(code*500/7) µs. Positive codes are forward and shorter, so +7 gives 1000 µs, 0 gives 1500 µs and -7 gives 2000 µs.
- R5: Drive code -8 is treated as -7, which gives 2000 µs.
- R6: Both command inputs are sampled only at the clock edge that starts a frame. A change during a pulse or later in the frame does not alter that frame's width.
- R7: While reset is asserted, both outputs are low. The first frame after reset is 1500 µs on both channels, regardless of the commands.
- R8: Steering codes 5, 6 and 7 give the straight width of 1500 µs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| steer_cmd | input | 3 | Steering position code |
| drive_cmd | input | 4 | Signed drive speed step |
| steer_pwm | output | 1 | Steering servo pulse train |
| drive_pwm | output | 1 | Speed controller pulse train |

## Verification
A wrong divider or frame counter shows up within one frame. Every pulse comes out too long or too short, or the spacing between rises drifts off the frame length. A wrong width register, or a capture at the wrong moment, is visible at the very next falling edge of the pulse it shapes. The bench measures every high interval and every rise-to-rise spacing in clock cycles. It compares them with widths computed from the command present at the frame-start edge, so a fault appears no later than one frame after its cause.

// File: rtl/servo_pulse_pair.sv
module servo_pulse_pair #(
  parameter int CLKS_PER_US = 100,
  parameter int FRAME_US    = 20000,
  parameter int CENTER_US   = 1500,
  parameter int SPAN_US     = 500,
  parameter int NUDGE_US    = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       steer_cmd,
  input  logic signed [3:0] drive_cmd,
  output logic             steer_pwm,
  output logic             drive_pwm
);
  localparam int DW    = $clog2(CLKS_PER_US + 1);
  localparam int FW    = $clog2(FRAME_US + 1);
  localparam int WW    = $clog2(CENTER_US + SPAN_US + 1);
  localparam int STEPS = 7;

  logic [DW-1:0] div_q;
  logic [FW-1:0] us_q;
  logic          armed_q;
  logic [WW-1:0] steer_w_q, drive_w_q, steer_w_d, drive_w_d;
  logic [WW-1:0] drv_off [STEPS+1];
  logic [3:0]    drv_mag;
  logic [2:0]    drv_idx;
  logic          tick, frame_end, drv_neg;

  assign tick      = (div_q == DW'(CLKS_PER_US - 1));
  assign frame_end = (us_q == FW'(FRAME_US - 1));

  for (genvar i = 0; i <= STEPS; i++) begin : g_off
    assign drv_off[i] = WW'((i * SPAN_US * 2 + STEPS) / (2 * STEPS));
  end

  assign drv_neg = drive_cmd[3];
  assign drv_mag = drv_neg ? 4'(-drive_cmd) : 4'(drive_cmd);
  assign drv_idx = drv_mag[3] ? 3'(STEPS) : drv_mag[2:0];
  assign drive_w_d = drv_neg ? WW'(CENTER_US) + drv_off[drv_idx]
                             : WW'(CENTER_US) - drv_off[drv_idx];

  always_comb begin
    case (steer_cmd)
      3'd1:    steer_w_d = WW'(CENTER_US - NUDGE_US);
      3'd2:    steer_w_d = WW'(CENTER_US - SPAN_US);
      3'd3:    steer_w_d = WW'(CENTER_US + NUDGE_US);
      3'd4:    steer_w_d = WW'(CENTER_US + SPAN_US);
      default: steer_w_d = WW'(CENTER_US);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      us_q      <= FW'(FRAME_US - 1);
      armed_q   <= 1'b0;
      steer_w_q <= WW'(CENTER_US);
      drive_w_q <= WW'(CENTER_US);
      steer_pwm <= 1'b0;
      drive_pwm <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (frame_end) begin
          us_q      <= '0;
          armed_q   <= 1'b1;
          steer_pwm <= 1'b1;
          drive_pwm <= 1'b1;
          if (armed_q) begin
            steer_w_q <= steer_w_d;
            drive_w_q <= drive_w_d;
          end
        end else begin
          us_q      <= us_q + 1'b1;
          steer_pwm <= (32'(us_q) + 32'd1) < 32'(steer_w_q);
          drive_pwm <= (32'(us_q) + 32'd1) < 32'(drive_w_q);
        end
      end
    end
  end
endmodule

module servo_pulse_pair_chk #(
  parameter int CLKS_PER_US = 100,
  parameter int CENTER_US   = 1500,
  parameter int SPAN_US     = 500,
  parameter int NUDGE_US    = 100,
  parameter int WW          = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          steer_pwm,
  input logic          drive_pwm,
  input logic          tick,
  input logic          frame_end,
  input logic [WW-1:0] steer_w,
  input logic [WW-1:0] drive_w
);
  int hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !drive_pwm) hi_cnt <= 0;
    else                   hi_cnt <= hi_cnt + 1;
  end

  assert_start_together_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_pwm) |-> $rose(drive_pwm));

  assert_tick_paced_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(steer_pwm) || !$stable(drive_pwm)) |-> $past(tick));

  assert_steer_width_legal_R3: assert property (@(posedge clk) disable iff (rst)
    (32'(steer_w) == CENTER_US) || (32'(steer_w) == CENTER_US - NUDGE_US) ||
    (32'(steer_w) == CENTER_US + NUDGE_US) || (32'(steer_w) == CENTER_US - SPAN_US) ||
    (32'(steer_w) == CENTER_US + SPAN_US));

  assert_drive_pulse_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= (CENTER_US + SPAN_US) * CLKS_PER_US);

  assert_frame_only_update_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(steer_w) || !$stable(drive_w)) |-> $past(tick && frame_end));

  assert_reset_low_R7: assert property (@(posedge clk)
    rst |=> (!steer_pwm && !drive_pwm));
endmodule

bind servo_pulse_pair servo_pulse_pair_chk #(
  .CLKS_PER_US(CLKS_PER_US), .CENTER_US(CENTER_US), .SPAN_US(SPAN_US),
  .NUDGE_US(NUDGE_US), .WW(WW)
) u_chk (
  .clk(clk), .rst(rst), .steer_pwm(steer_pwm), .drive_pwm(drive_pwm),
  .tick(tick), .frame_end(frame_end), .steer_w(steer_w_q), .drive_w(drive_w_q)
);

// File: tb/sim_servo_pulse_pair.sv
module sim_servo_pulse_pair;
  localparam int CLKS  = 2;
  localparam int FRAME = 2100;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] steer_cmd = 3'd4;
  logic signed [3:0] drive_cmd = 4'sd7;
  logic steer_pwm, drive_pwm;

  int checks = 0, errors = 0, cyc = 0;
  logic [2:0] cap_s;
  logic signed [3:0] cap_d;
  bit first = 1, seen = 0, r6_mode = 0;
  bit prev_s = 0, prev_d = 0;
  int len_s = 0, len_d = 0, exp_s = 0, exp_d = 0, last_rise = 0;
  string tag_s, tag_d;
  event rise_ev;

  servo_pulse_pair #(.CLKS_PER_US(CLKS), .FRAME_US(FRAME)) u0 (
    .clk(clk), .rst(rst), .steer_cmd(steer_cmd), .drive_cmd(drive_cmd),
    .steer_pwm(steer_pwm), .drive_pwm(drive_pwm));

  always #2.5 clk = ~clk;

  function automatic int steer_exp(input logic [2:0] c);
    case (c)
      3'd1: return 1400;
      3'd2: return 1000;
      3'd3: return 1600;
      3'd4: return 2000;
      default: return 1500;
    endcase
  endfunction

  function automatic int drive_exp(input logic signed [3:0] d);
    int v = int'(d);
    int m = (v < 0) ? -v : v;
    int off;
    if (m > 7) m = 7;
    off = int'(m * 500.0 / 7.0);
    return (v < 0) ? 1500 + off : 1500 - off;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cap_s <= steer_cmd;
    cap_d <= drive_cmd;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      first = 1; seen = 0; prev_s = 0; prev_d = 0; len_s = 0; len_d = 0;
    end else begin
      if (steer_pwm && !prev_s) begin
        chk(int'(drive_pwm && !prev_d), 1, "R1 rise together");
        if (seen) chk(cyc - last_rise, FRAME * CLKS, "R1 period");
        seen = 1; last_rise = cyc;
        if (first) begin
          exp_s = 1500; exp_d = 1500; tag_s = "R7 R2"; tag_d = "R7 R2";
        end else begin
          exp_s = steer_exp(cap_s); exp_d = drive_exp(cap_d);
          tag_s = (cap_s > 3'd4) ? "R8" : "R3";
          tag_d = (cap_d == -4'sd8) ? "R5" : "R4";
          if (r6_mode) begin tag_s = "R6"; tag_d = "R6"; end
        end
        first = 0;
        ->rise_ev;
      end
      if (steer_pwm) len_s++;
      if (drive_pwm) len_d++;
      if (!steer_pwm && prev_s) begin chk(len_s, exp_s * CLKS, tag_s); len_s = 0; end
      if (!drive_pwm && prev_d) begin chk(len_d, exp_d * CLKS, tag_d); len_d = 0; end
      prev_s = steer_pwm; prev_d = drive_pwm;
    end
  end

  task automatic frame_with(input logic [2:0] s, input logic signed [3:0] d);
    @(rise_ev);
    @(negedge clk);
    steer_cmd = s; drive_cmd = d;
  endtask

  initial begin
    void'($urandom(1234));
    repeat (5) @(negedge clk);
    chk(int'(steer_pwm) + int'(drive_pwm), 0, "R7 low in reset");
    rst = 1'b0;
    frame_with(3'd1, 4'sd7);
    frame_with(3'd2, 4'sd0);
    frame_with(3'd3, -4'sd7);
    frame_with(3'd5, -4'sd8);
    frame_with(3'd6, 4'sd1);
    frame_with(3'd7, -4'sd3);
    frame_with(3'd0, 4'sd6);
    @(rise_ev);
    r6_mode = 1;
    repeat (200) @(negedge clk);
    steer_cmd = 3'd4; drive_cmd = -4'sd7;
    repeat (1000) @(negedge clk);
    steer_cmd = 3'd2; drive_cmd = 4'sd5;
    @(rise_ev);
    r6_mode = 0;
    repeat (500) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(int'(steer_pwm) + int'(drive_pwm), 0, "R7 reset mid-pulse");
    steer_cmd = 3'd3; drive_cmd = -4'sd5;
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(rise_ev);
      repeat ($urandom_range(4000, 1)) @(negedge clk);
      steer_cmd = 3'($urandom_range(7, 0));
      drive_cmd = 4'($urandom_range(15, 0));
    end
    @(rise_ev);
    repeat (FRAME * CLKS - 50) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule